// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Array Multiplier

This block multiplies two unsigned 16-bit operands and returns the full 32-bit product. The product is built by splitting each operand into an upper and a lower half and forming four half-width products at the same time: lower by lower, lower by upper, upper by lower, and upper by upper. Each of those products is built the same way again, one level down, until the operands are 2 bits wide. At that size a small cell of AND gates and two half adders forms the product.

At every level, the lower half of the low-by-low product goes straight to the lowest result bits. The two cross products are added together, and the carry out of that sum is kept. The sum is then added to the rest of the low product and the high product at their weights. Every addition uses a parallel-prefix (Kogge-Stone) adder, so the carry chain at each level takes a logarithmic number of gate levels.

The multiplier array is purely combinational. By default a register with a clock enable holds the result. The asynchronous active-low reset of that register is released through a two-stage synchronizer. A parameter removes the register, which leaves the block purely combinational.

Top module: `vcm_mult16`

## Requirements
- R1: With the output register present, when `load_en` is 1 at a rising clock edge and the block is out of reset, `prod_o` shows the unsigned product `opa_i * opb_i` after that edge.
- R2: If either operand is 0, the loaded product is 0.
- R3: The all-ones operands 0xFFFF and 0xFFFF give 0xFFFE0001. This case checks that the carry out of the cross-product sum is not lost.
- R4: Two powers of two, 2^i and 2^j with i and j from 0 to 15, give exactly 2^(i+j) with one bit set.
- R5: When `load_en` is 0 at a rising edge, `prod_o` keeps its previous value, whatever the operands are.
- R6: While `rst_n` is 0, `prod_o` is 0. After `rst_n` rises, the register stays in reset for two rising edges. An operand pair loaded at the third edge appears after that edge.
- R7: An operand of 1 returns the other operand unchanged in the lower 16 bits, and the upper 16 bits are 0.
- R8: The combinational product of the array equals the unsigned product of the current operands for any operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_en | input | 1 | Clock enable: capture a new product at this edge |
| opa_i | input | 16 | Unsigned multiplicand |
| opb_i | input | 16 | Unsigned multiplier |
| prod_o | output | 32 | Unsigned product |

## Verification
A pair of operands applied with `load_en` high is due at `prod_o` one rising edge later. The bench therefore drives inputs on a falling edge and compares the output on the following falling edge, half a period after the capturing edge. A release of reset makes the register ready only at the third rising edge. The bench checks for 0 after the first edge and checks the loaded product after the third. For hold checks, the bench changes the operands with the enable low and confirms one cycle later that the output still shows the earlier product.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // True when n is a power of two and at least 2 (recursion bottoms out at 2x2).
  function automatic bit width_ok(int n);
    int v;
    v = n;
    if (v < 2) return 1'b0;
    while (v > 1) begin
      if (v % 2 != 0) return 1'b0;
      v = v / 2;
    end
    return 1'b1;
  endfunction

  // Number of prefix levels needed for a w-bit carry network.
  function automatic int prefix_levels(int w);
    int l;
    l = 0;
    while ((1 << l) < w) l++;
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/vcm_ks_adder.sv
// Parallel-prefix adder with carry out: s = x + y, W+1 bits.
module vcm_ks_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   s
);
  localparam int LVL = vcm_pkg::prefix_levels(W);

  logic [W-1:0] gen_l  [0:LVL];
  logic [W-1:0] prop_l [0:LVL-1];

  assign gen_l[0]  = x & y;
  assign prop_l[0] = x ^ y;

  for (genvar k = 0; k < LVL; k++) begin : g_stage
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gen_l[k+1][i] = gen_l[k][i] | (prop_l[k][i] & gen_l[k][i-D]);
        if (k + 1 < LVL) begin : g_p
          assign prop_l[k+1][i] = prop_l[k][i] & prop_l[k][i-D];
        end
      end else begin : g_pass
        assign gen_l[k+1][i] = gen_l[k][i];
        if (k + 1 < LVL) begin : g_p
          assign prop_l[k+1][i] = prop_l[k][i];
        end
      end
    end
  end

  assign s[0] = prop_l[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign s[i] = prop_l[0][i] ^ gen_l[LVL][i-1];
  end
  assign s[W] = gen_l[LVL][W-1];
endmodule

// File: rtl/vcm_base2x2.sv
// 2x2 unsigned product from AND terms and two half adders.
module vcm_base2x2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic t00, t10, t01, t11, c_mid;

  always_comb begin
    t00 = a[0] & b[0];
    t10 = a[1] & b[0];
    t01 = a[0] & b[1];
    t11 = a[1] & b[1];
    // first half adder: cross terms
    p[1]  = t10 ^ t01;
    c_mid = t10 & t01;
    // second half adder: top term plus carry
    p[2]  = t11 ^ c_mid;
    p[3]  = t11 & c_mid;
    p[0]  = t00;
  end
endmodule

// File: rtl/vcm_node.sv
// One recursion level: four half-width products merged with prefix adders.
module vcm_node #(
  parameter int N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  if (N == 2) begin : g_leaf
    vcm_base2x2 u_cell (.a(a), .b(b), .p(p));
  end else begin : g_split
    localparam int H  = N / 2;
    localparam int UW = 3 * H;

    logic [N-1:0]  p_ll, p_lh, p_hl, p_hh;
    logic [N:0]    cross_sum;
    logic [UW-1:0] up_x, up_y;
    logic [UW:0]   up_sum;
    logic          carry_unused;

    vcm_node #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
    vcm_node #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(p_lh));
    vcm_node #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(p_hl));
    vcm_node #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(p_hh));

    // crosswise terms, carry out kept in cross_sum[N]
    vcm_ks_adder #(.W(N)) u_cross (.x(p_lh), .y(p_hl), .s(cross_sum));

    // upper 3H result bits: {high product, upper half of low product} + cross sum
    assign up_x = {p_hh, p_ll[N-1:H]};
    assign up_y = {{(UW-N-1){1'b0}}, cross_sum};

    vcm_ks_adder #(.W(UW)) u_upper (.x(up_x), .y(up_y), .s(up_sum));

    assign carry_unused = up_sum[UW];
    assign p = {up_sum[UW-1:0], p_ll[H-1:0]};
  end
endmodule

// File: rtl/vcm_rst_sync.sv
// Asynchronous assert, two-stage synchronous release.
module vcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/vcm_mult16.sv
module vcm_mult16 #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [WIDTH-1:0]   opa_i,
  input  logic [WIDTH-1:0]   opb_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  if (!vcm_pkg::width_ok(WIDTH)) begin : g_bad_width
    $error("vcm_mult16: WIDTH must be a power of two, at least 2");
  end

  logic [PW-1:0] prod_comb;
  logic          rst_ok;

  vcm_node #(.N(WIDTH)) u_array (.a(opa_i), .b(opb_i), .p(prod_comb));

  vcm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q, prod_d;

    always_comb prod_d = load_en ? prod_comb : prod_q;

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) prod_q <= '0;
      else         prod_q <= prod_d;
    end

    assign prod_o = prod_q;
  end else begin : g_comb
    logic ctl_unused;
    assign ctl_unused = load_en;
    assign prod_o     = prod_comb;
  end
endmodule

// File: rtl/vcm_mult16_chk.sv
module vcm_mult16_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_ok,
  input logic               load_en,
  input logic [WIDTH-1:0]   opa_i,
  input logic [WIDTH-1:0]   opb_i,
  input logic [2*WIDTH-1:0] prod_comb,
  input logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  a_r1_loaded_product: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && rst_ok) |=> prod_o == (PW'($past(opa_i)) * PW'($past(opb_i))));

  a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && rst_ok && (opa_i == '0 || opb_i == '0)) |=> prod_o == '0);

  a_r4_one_hot_product: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && rst_ok && $onehot0(opa_i) && $onehot0(opb_i) && opa_i != '0 && opb_i != '0)
      |=> $countones(prod_o) == 1);

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && rst_ok) |=> $stable(prod_o));

  a_r6_zero_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> prod_o == '0);

  a_r8_array_exact: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok |-> prod_comb == (PW'(opa_i) * PW'(opb_i)));
endmodule

bind vcm_mult16 vcm_mult16_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok), .load_en(load_en),
  .opa_i(opa_i), .opb_i(opb_i), .prod_comb(prod_comb), .prod_o(prod_o)
);

// File: tb/vcm_mult16_test.sv
`timescale 1ns/1ps
module vcm_mult16_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [15:0] opa_i, opb_i;
  logic [31:0] prod_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  vcm_mult16 uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .opa_i(opa_i), .opb_i(opb_i), .prod_o(prod_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // drive at falling edge, capture at next rising edge, compare at next falling edge
  task automatic load_and_check(input string req, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opa_i = a; opb_i = b; load_en = 1'b1;
    @(negedge clk);
    check(req, prod_o, {16'h0, a} * {16'h0, b});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load_en = 1'b1; opa_i = 16'd3; opb_i = 16'd5;
    repeat (3) @(negedge clk);
    check("R6 during reset", prod_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 first edge after release", prod_o, 32'h0);
    @(negedge clk);
    @(negedge clk);
    check("R6 third edge after release", prod_o, 32'd15);
  endtask

  task automatic t_zero;
    load_and_check("R2 zero a", 16'h0000, 16'hBEEF);
    load_and_check("R2 zero b", 16'h1234, 16'h0000);
    load_and_check("R2 zero both", 16'h0000, 16'h0000);
  endtask

  task automatic t_all_ones;
    load_and_check("R3 all ones", 16'hFFFF, 16'hFFFF);
    check("R3 literal", prod_o, 32'hFFFE0001);
    load_and_check("R3 cross carry", 16'hFF00, 16'h00FF);
  endtask

  task automatic t_one;
    load_and_check("R7 one times b", 16'h0001, 16'hA5C3);
    load_and_check("R7 a times one", 16'h7E81, 16'h0001);
  endtask

  task automatic t_pow2;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j += 5) begin
        load_and_check("R4 power of two", 16'(1 << i), 16'(1 << j));
        check("R4 single bit", prod_o, 32'(1) << (i + j));
      end
    end
  endtask

  task automatic t_hold;
    logic [31:0] kept;
    load_and_check("R5 setup", 16'h1357, 16'h2468);
    kept = prod_o;
    @(negedge clk);
    opa_i = 16'hFFFF; opb_i = 16'hFFFF; load_en = 1'b0;
    @(negedge clk);
    check("R5 hold after operand change", prod_o, kept);
    opa_i = 16'h0000;
    @(negedge clk);
    check("R5 hold second cycle", prod_o, kept);
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      load_and_check("R1 random pair", 16'($urandom), 16'($urandom));
    end
    load_and_check("R8 max times two", 16'hFFFF, 16'h0002);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    t_reset();
    t_zero();
    t_all_ones();
    t_one();
    t_pow2();
    t_hold();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule